// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Masking

This block decides which pending interrupt request the processor should service next, and it outputs that request's vector index. It takes several kinds of request. An illegal-opcode trap and a software interrupt cannot be masked. An external non-maskable line is gated only by the X mask bit. An active-low external IRQ line and a parameterised set of on-chip sources are maskable: the global I bit gates all of them, and each on-chip source also has its own enable. The block holds the I and X bits, the enables, a promotion register and the IRQ sensing mode. The processor's stacking sequence is outside the block.

The processor signals interrupt entry with a one-cycle acknowledge. On entry the block sets I, and it also sets X when the serviced vector is the non-maskable line. On return from interrupt the processor presents the saved I and X bits and pulses a return strobe. The X bit can only be cleared from software. After that, only reset or entry for the non-maskable line can set it again. The promotion register moves one maskable source to the top of the maskable order. The IRQ line can be sensed by level or by falling edge. The sensing-mode bit can only be changed during a short window after reset.

Top module: `int_arbiter`

## Requirements
- R1: Coming out of reset, I=1, X=1, all on-chip enables are 0, promotion is 0 and IRQ sensing is level. In this state, only trap and software requests produce `valid_o`.
- R2: While I=1, the IRQ line and the on-chip sources are neither pending nor selected. A strobe on `imask_set_i` sets I and a strobe on `imask_clr_i` clears it, both effective after the next clock edge. If both strobes arrive together, set wins.
- R3: The non-maskable line (`xirq_i`, active high) is pending only while X=0. `xmask_clr_i` clears X. No software input sets X: a return strobe can only keep X or clear it.
- R4: An acknowledge (`ack_i` while `valid_o` is high) sets I after the edge. It also sets X when `vec_o` is 2, and it clears the edge-mode IRQ latch when `vec_o` is 3. In the same cycle, an acknowledge overrides the return strobe and the mask strobes.
- R5: A return strobe (`rti_i`) without an acknowledge loads I from `rti_imask_i` and loads X with X AND `rti_xmask_i`.
- R6: Vector indices are fixed: trap is 0, software interrupt is 1, non-maskable line is 2, IRQ is 3, and on-chip source k is 4+k. Vectors 0, 1 and 2 win in that order over every maskable vector. Among maskables, the lowest index wins by default.
- R7: A promotion value p (0 to NSRC) makes vector 3+p the winner among pending maskables. A promotion write with a value above NSRC is ignored.
- R8: On-chip source k is pending only when its enable bit k is 1.
- R9: In level mode, IRQ is pending in the same cycle that `irq_n_i` is low. In edge mode, a falling edge is latched and IRQ becomes pending after the next clock edge. It stays pending after the line rises until it is acknowledged. A line held low does not set the latch again.
- R10: A write to the sensing mode takes effect only while fewer than CFG_WINDOW (64) clock edges have passed since reset was released. Later writes are ignored.
- R11: `pend_o` bit i shows that vector i is unmasked and requesting. `valid_o` is the OR of these bits. `vec_o` is 0 when `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | Illegal-opcode trap request |
| swi_i | input | 1 | Software interrupt request |
| xirq_i | input | 1 | Non-maskable line request, active high |
| irq_n_i | input | 1 | External IRQ line, active low |
| src_req_i | input | NSRC | On-chip maskable requests |
| imask_set_i | input | 1 | Set I strobe |
| imask_clr_i | input | 1 | Clear I strobe |
| xmask_clr_i | input | 1 | Clear X strobe |
| ack_i | input | 1 | Interrupt-entry strobe for the current `vec_o` |
| rti_i | input | 1 | Return-from-interrupt strobe |
| rti_imask_i | input | 1 | Saved I bit restored on return |
| rti_xmask_i | input | 1 | Saved X bit restored on return |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NSRC | Enable register write data |
| prio_we_i | input | 1 | Promotion register write strobe |
| prio_wdata_i | input | clog2(NSRC+1) | Promotion register write data |
| sense_we_i | input | 1 | Sensing mode write strobe |
| sense_edge_i | input | 1 | Sensing mode data: 1 is edge, 0 is level |
| pend_o | output | NSRC+4 | Per-vector pending bitmap |
| valid_o | output | 1 | Some vector is pending |
| vec_o | output | clog2(NSRC+4) | Index of the winning vector |

## Verification
Request inputs reach `pend_o`, `valid_o` and `vec_o` through logic alone, so their effect is due in the same cycle. Every strobe and register write (masks, enables, promotion, sensing mode, acknowledge, return) shows up only after one clock edge. An edge-mode IRQ falling edge also needs one edge before it appears. The bench drives its inputs just after a falling clock edge and samples 1 ns later. For a registered effect, it first lets exactly one rising edge pass before sampling. It also samples once before that edge, which confirms that an edge-mode request is not yet pending at that point.

// File: rtl/int_arb_pkg.sv
package int_arb_pkg;
    // Fixed vector indices; maskable sources follow VEC_IRQ in order
    localparam int unsigned VEC_TRAP  = 0;
    localparam int unsigned VEC_SWI   = 1;
    localparam int unsigned VEC_XIRQ  = 2;
    localparam int unsigned VEC_IRQ   = 3;
    localparam int unsigned VEC_SRC0  = 4;
    localparam int unsigned NUM_FIXED = 4;
endpackage

// File: rtl/irq_sense.sv
module irq_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic req_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } sense_t;

    sense_t s_d, s_q;
    logic   fall;

    always_comb begin
        s_d       = s_q;
        fall      = s_q.prev & ~line_n_i;
        s_d.prev  = line_n_i;
        // a fresh falling edge wins over a clear in the same cycle
        s_d.latch = edge_mode_i & (fall | (s_q.latch & ~clr_i));
        req_o     = edge_mode_i ? s_q.latch : ~line_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b1, latch: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/int_pick.sv
module int_pick import int_arb_pkg::*; #(
    parameter int unsigned NSRC = 4
) (
    input  logic [NUM_FIXED+NSRC-1:0]         pend_i,
    input  logic [$clog2(NSRC+1)-1:0]         prio_i,
    output logic                              valid_o,
    output logic [$clog2(NUM_FIXED+NSRC)-1:0] vec_o
);
    localparam int unsigned VW = $clog2(NUM_FIXED + NSRC);

    always_comb begin
        vec_o   = '0;
        valid_o = |pend_i;
        // default maskable order: lowest index wins
        for (int k = int'(NSRC); k >= 0; k--) begin
            if (pend_i[int'(VEC_IRQ) + k]) vec_o = VW'(int'(VEC_IRQ) + k);
        end
        // promoted maskable source overrides the default order
        if (pend_i[int'(VEC_IRQ) + int'(prio_i)]) vec_o = VW'(int'(VEC_IRQ) + int'(prio_i));
        // non-maskable sources outrank every maskable one
        if (pend_i[VEC_XIRQ]) vec_o = VW'(VEC_XIRQ);
        if (pend_i[VEC_SWI])  vec_o = VW'(VEC_SWI);
        if (pend_i[VEC_TRAP]) vec_o = VW'(VEC_TRAP);
    end
endmodule

// File: rtl/int_arbiter.sv
module int_arbiter import int_arb_pkg::*; #(
    parameter int unsigned NSRC       = 4,
    parameter int unsigned CFG_WINDOW = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              trap_i,
    input  logic                              swi_i,
    input  logic                              xirq_i,
    input  logic                              irq_n_i,
    input  logic [NSRC-1:0]                   src_req_i,
    input  logic                              imask_set_i,
    input  logic                              imask_clr_i,
    input  logic                              xmask_clr_i,
    input  logic                              ack_i,
    input  logic                              rti_i,
    input  logic                              rti_imask_i,
    input  logic                              rti_xmask_i,
    input  logic                              en_we_i,
    input  logic [NSRC-1:0]                   en_wdata_i,
    input  logic                              prio_we_i,
    input  logic [$clog2(NSRC+1)-1:0]         prio_wdata_i,
    input  logic                              sense_we_i,
    input  logic                              sense_edge_i,
    output logic [NUM_FIXED+NSRC-1:0]         pend_o,
    output logic                              valid_o,
    output logic [$clog2(NUM_FIXED+NSRC)-1:0] vec_o
);
    localparam int unsigned NVEC = NUM_FIXED + NSRC;
    localparam int unsigned VW   = $clog2(NVEC);
    localparam int unsigned PW   = $clog2(NSRC + 1);
    localparam int unsigned CW   = $clog2(CFG_WINDOW + 1);

    typedef struct packed {
        logic            imask;
        logic            xmask;
        logic [NSRC-1:0] en;
        logic [PW-1:0]   prio;
        logic            edge_mode;
        logic [CW-1:0]   cnt;
    } state_t;

    state_t st_d, st_q;
    logic   imask_q, xmask_q, edge_q;
    logic [NSRC-1:0] en_q;
    logic [CW-1:0]   cnt_q;
    logic   irq_req, ack_hit, irq_clr, in_window;

    assign imask_q = st_q.imask;
    assign xmask_q = st_q.xmask;
    assign edge_q  = st_q.edge_mode;
    assign en_q    = st_q.en;
    assign cnt_q   = st_q.cnt;

    assign ack_hit   = ack_i & valid_o;
    assign irq_clr   = ack_hit & (vec_o == VW'(VEC_IRQ));
    assign in_window = cnt_q < CW'(CFG_WINDOW);

    irq_sense sense_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_n_i    (irq_n_i),
        .edge_mode_i (edge_q),
        .clr_i       (irq_clr),
        .req_o       (irq_req)
    );

    always_comb begin
        pend_o                    = '0;
        pend_o[VEC_TRAP]          = trap_i;
        pend_o[VEC_SWI]           = swi_i;
        pend_o[VEC_XIRQ]          = xirq_i & ~xmask_q;
        pend_o[VEC_IRQ]           = irq_req & ~imask_q;
        pend_o[VEC_SRC0 +: NSRC]  = src_req_i & en_q & {NSRC{~imask_q}};
    end

    int_pick #(.NSRC(NSRC)) pick_i (
        .pend_i  (pend_o),
        .prio_i  (st_q.prio),
        .valid_o (valid_o),
        .vec_o   (vec_o)
    );

    always_comb begin
        st_d = st_q;
        if (in_window) st_d.cnt = cnt_q + CW'(1);
        if (sense_we_i && in_window) st_d.edge_mode = sense_edge_i;
        if (en_we_i) st_d.en = en_wdata_i;
        if (prio_we_i && (prio_wdata_i <= PW'(NSRC))) st_d.prio = prio_wdata_i;
        if (ack_hit) begin
            st_d.imask = 1'b1;
            if (vec_o == VW'(VEC_XIRQ)) st_d.xmask = 1'b1;
        end else if (rti_i) begin
            st_d.imask = rti_imask_i;
            st_d.xmask = xmask_q & rti_xmask_i;
        end else begin
            if (imask_set_i)      st_d.imask = 1'b1;
            else if (imask_clr_i) st_d.imask = 1'b0;
            if (xmask_clr_i)      st_d.xmask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{imask: 1'b1, xmask: 1'b1, en: '0, prio: '0,
                      edge_mode: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/int_arbiter_chk.sv
module int_arbiter_chk import int_arb_pkg::*; #(
    parameter int unsigned NSRC       = 4,
    parameter int unsigned CFG_WINDOW = 64
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  ack_i,
    input logic                                  imask,
    input logic                                  xmask,
    input logic                                  edge_mode,
    input logic [$clog2(CFG_WINDOW+1)-1:0]       cnt,
    input logic [NUM_FIXED+NSRC-1:0]             pend_o,
    input logic                                  valid_o,
    input logic [$clog2(NUM_FIXED+NSRC)-1:0]     vec_o
);
    localparam int unsigned VW = $clog2(NUM_FIXED + NSRC);
    localparam int unsigned CW = $clog2(CFG_WINDOW + 1);

    assert_imask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imask |-> !(valid_o && (vec_o >= VW'(VEC_IRQ))));

    assert_xmask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xmask |-> !pend_o[VEC_XIRQ]);

    assert_x_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xmask && !(ack_i && valid_o && (vec_o == VW'(VEC_XIRQ)))) |=> !xmask);

    assert_entry_sets_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && valid_o) |=> imask);

    assert_trap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[VEC_TRAP] |-> (valid_o && (vec_o == VW'(VEC_TRAP))));

    assert_sel_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_o[vec_o]);

    assert_sense_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CW'(CFG_WINDOW)) |=> $stable(edge_mode));
endmodule

bind int_arbiter int_arbiter_chk #(.NSRC(NSRC), .CFG_WINDOW(CFG_WINDOW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_i),
    .imask     (imask_q),
    .xmask     (xmask_q),
    .edge_mode (edge_q),
    .cnt       (cnt_q),
    .pend_o    (pend_o),
    .valid_o   (valid_o),
    .vec_o     (vec_o)
);

// File: tb/int_arbiter_tb_top.sv
module int_arbiter_tb_top;
    localparam int NSRC = 4;
    localparam int NVEC = NSRC + 4;
    localparam int VW   = $clog2(NVEC);
    localparam int PW   = $clog2(NSRC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_i, swi_i, xirq_i, irq_n_i;
    logic [NSRC-1:0] src_req_i;
    logic imask_set_i, imask_clr_i, xmask_clr_i, ack_i, rti_i, rti_imask_i, rti_xmask_i;
    logic en_we_i, prio_we_i, sense_we_i, sense_edge_i;
    logic [NSRC-1:0] en_wdata_i;
    logic [PW-1:0]   prio_wdata_i;
    logic [NVEC-1:0] pend_o;
    logic            valid_o;
    logic [VW-1:0]   vec_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    int_arbiter #(.NSRC(NSRC), .CFG_WINDOW(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .swi_i(swi_i), .xirq_i(xirq_i),
        .irq_n_i(irq_n_i), .src_req_i(src_req_i), .imask_set_i(imask_set_i),
        .imask_clr_i(imask_clr_i), .xmask_clr_i(xmask_clr_i), .ack_i(ack_i),
        .rti_i(rti_i), .rti_imask_i(rti_imask_i), .rti_xmask_i(rti_xmask_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .prio_we_i(prio_we_i),
        .prio_wdata_i(prio_wdata_i), .sense_we_i(sense_we_i), .sense_edge_i(sense_edge_i),
        .pend_o(pend_o), .valid_o(valid_o), .vec_o(vec_o)
    );

    task automatic check_out(input string req, input bit ev, input int evec, input int epend);
        int act, exp;
        act = {valid_o, 4'(vec_o), 8'(pend_o)};
        exp = {ev, 4'(evec), 8'(epend)};
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual valid=%0d vec=%0d pend=%02h expected valid=%0d vec=%0d pend=%02h",
                     req, valid_o, vec_o, pend_o, ev, evec, epend[7:0]);
        end
    endtask

    task automatic idle();
        trap_i = 0; swi_i = 0; xirq_i = 0; irq_n_i = 1; src_req_i = '0;
        imask_set_i = 0; imask_clr_i = 0; xmask_clr_i = 0; ack_i = 0; rti_i = 0;
        rti_imask_i = 0; rti_xmask_i = 0; en_we_i = 0; en_wdata_i = '0;
        prio_we_i = 0; prio_wdata_i = '0; sense_we_i = 0; sense_edge_i = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // strobes are held across exactly one rising edge
    task automatic edge_pass();
        @(negedge clk);
        imask_set_i = 0; imask_clr_i = 0; xmask_clr_i = 0; ack_i = 0; rti_i = 0;
        en_we_i = 0; prio_we_i = 0; sense_we_i = 0;
        #1;
    endtask

    task automatic wr_en(input int v);
        en_we_i = 1; en_wdata_i = NSRC'(v); edge_pass();
    endtask

    task automatic wr_prio(input int v);
        prio_we_i = 1; prio_wdata_i = PW'(v); edge_pass();
    endtask

    function automatic int exp_mvec(input int m, input int p);
        if (m[p]) return 3 + p;
        for (int b = 0; b <= NSRC; b++) if (m[b]) return 3 + b;
        return 0;
    endfunction

    function automatic int low_src(input int e);
        for (int b = 0; b < NSRC; b++) if (e[b]) return 4 + b;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1: reset masks everything maskable
        xirq_i = 1; irq_n_i = 0; src_req_i = '1; #1;
        check_out("R1 reset masks", 0, 0, 0);
        trap_i = 1; #1;
        check_out("R1 trap serviced after reset", 1, 0, 8'h01);
        swi_i = 1; #1;
        check_out("R6 trap over swi", 1, 0, 8'h03);
        trap_i = 0; #1;
        check_out("R6 swi alone", 1, 1, 8'h02);
        swi_i = 0; irq_n_i = 1;
        @(negedge clk); xmask_clr_i = 1; edge_pass();
        check_out("R3 x cleared unmasks xirq", 1, 2, 8'h04);
        imask_clr_i = 1; edge_pass();
        wr_en(15);
        check_out("R6 xirq over maskables", 1, 2, 8'hF4);
        xirq_i = 0; #1;
        irq_n_i = 0; src_req_i = '0; #1;
        check_out("R9 level irq pending same cycle", 1, 3, 8'h08);
        irq_n_i = 1; #1;
        check_out("R9 level irq released", 0, 0, 0);

        // R6/R7 sweep over promotion and maskable patterns
        for (int p = 0; p <= NSRC; p++) begin
            wr_prio(p);
            for (int m = 0; m < (1 << (NSRC + 1)); m++) begin
                irq_n_i = ~m[0]; src_req_i = NSRC'(m >> 1); #1;
                check_out("R7 promotion sweep", m != 0, exp_mvec(m, p), m << 3);
            end
        end
        irq_n_i = 1;
        wr_prio(2);
        wr_prio(NSRC + 1);
        src_req_i = '1; #1;
        check_out("R7 out-of-range promotion ignored", 1, 5, 8'hF0);
        wr_prio(0);

        // R8 enable sweep
        for (int e = 0; e < (1 << NSRC); e++) begin
            wr_en(e);
            check_out("R8 enable sweep", e != 0, low_src(e), e << 4);
        end
        wr_en(15);

        // R2 I mask strobes
        imask_set_i = 1; imask_clr_i = 1; edge_pass();
        check_out("R2 set wins, maskables blocked", 0, 0, 0);
        imask_clr_i = 1; edge_pass();
        check_out("R2 clear re-enables", 1, 4, 8'hF0);

        // R4/R5 entry and return
        src_req_i = '0; xirq_i = 1; #1;
        check_out("R4 xirq pending before entry", 1, 2, 8'h04);
        ack_i = 1; edge_pass();
        src_req_i = '1; #1;
        check_out("R4 entry sets I and X", 0, 0, 0);
        rti_i = 1; rti_imask_i = 0; rti_xmask_i = 0; edge_pass();
        check_out("R5 return restores clear bits", 1, 2, 8'hF4);
        rti_i = 1; rti_imask_i = 0; rti_xmask_i = 1; edge_pass();
        check_out("R3 return cannot set X", 1, 2, 8'hF4);
        rti_i = 1; rti_imask_i = 1; rti_xmask_i = 1; edge_pass();
        check_out("R5 return restores I set", 1, 2, 8'h04);
        rti_i = 1; rti_imask_i = 0; rti_xmask_i = 0; edge_pass();
        ack_i = 1; imask_clr_i = 1; edge_pass();
        check_out("R4 entry overrides clear strobe", 0, 0, 0);

        // phase 2: edge sensing
        do_reset();
        sense_we_i = 1; sense_edge_i = 1; edge_pass();
        imask_clr_i = 1; edge_pass();
        irq_n_i = 0; #1;
        check_out("R9 edge not pending before clock", 0, 0, 0);
        @(negedge clk); #1;
        check_out("R9 edge latched", 1, 3, 8'h08);
        irq_n_i = 1; @(negedge clk); #1;
        check_out("R9 latch held after line rises", 1, 3, 8'h08);
        ack_i = 1; edge_pass();
        imask_clr_i = 1; edge_pass();
        check_out("R4 entry clears edge latch", 0, 0, 0);
        irq_n_i = 0; @(negedge clk); #1;
        ack_i = 1; edge_pass();
        imask_clr_i = 1; edge_pass();
        @(negedge clk); #1;
        check_out("R9 held-low line does not relatch", 0, 0, 0);

        // R10 window closed
        repeat (80) @(negedge clk);
        sense_we_i = 1; sense_edge_i = 0; edge_pass();
        check_out("R10 late level write ignored", 0, 0, 0);
        irq_n_i = 1; @(negedge clk);
        irq_n_i = 0; @(negedge clk); #1;
        check_out("R10 still edge sensing", 1, 3, 8'h08);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule